// File: doc/BRIEF.md
# DRAM Rank Refresh Scheduler

This block sits between a DRAM controller's command arbiter and its command bus and decides when each rank is refreshed. Each rank has a small pending-refresh counter. Before a rank is refreshed, the block raises that rank's block line so the arbiter stops sending new accesses to it. It then waits until the arbiter reports the rank idle, sends a precharge-all to close every bank, and only then sends the refresh. Banks are never closed early through read or write auto-precharge.

The source of refresh demand is fixed when the block is built. In the default internal mode, an interval timer adds one to every rank's counter each period. Up to six refreshes may be deferred while a rank is busy. In user mode, no interval is tracked. Instead, each rank has an asynchronous four-phase request/acknowledge handshake, and each completed handshake adds one to that rank's counter. After a refresh, a ZQ short-calibration can follow once a calibration interval has elapsed, unless an input blocks it.

Top module: `rfsh_sched`

## Requirements
- R1: Before every refresh or ZQ command, `rank_block[r]` rises for the target rank and stays high. The block then waits until `rank_idle[r]` is seen high, and a precharge-all to rank r is accepted before the refresh or ZQ command to that rank.
- R2: `cmd_op` encodes 0 = none, 1 = precharge-all, 2 = refresh, 3 = ZQ short calibration. A command is held valid, with `cmd_op` and `cmd_rank` stable, until `cmd_ready` accepts it.
- R3: In internal mode (USER_MODE = 0), each rank's pending counter gains one every REFI_CYCLES cycles after reset. With all ranks idle, each rank has received n refreshes after n intervals.
- R4: A rank with pending refreshes is served without forcing only while `rank_idle` is high. Once its counter reaches POSTPONE_LIMIT (6), it is blocked and served even if busy, ahead of non-urgent work. Among urgent ranks, the lowest index goes first.
- R5: In user mode, each completed handshake on `usr_req[r]`/`usr_ack[r]` yields exactly one refresh to rank r.
- R6: `usr_ack[r]` rises no more than 16 cycles after `usr_req[r]` rises. It stays high while the request stays high, and falls only after the synchronized request is seen low (two-flop synchronizer).
- R7: `port_ready` is the registered `calib_done` in user mode and is always 0 in internal mode. While `port_ready` is low, requests are ignored: no acknowledge and no refresh. In internal mode, `usr_ack` stays 0.
- R8: A pending counter saturates at 7. Nine handshakes made while the command bus is stalled produce exactly seven refreshes.
- R9: A refresh accepted while the ZQ timer is idle arms it. ZQ_CYCLES cycles later, a ZQ command is issued to that rank, preceded by its precharge-all. If `zq_block` is high when the timer expires, no ZQ command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| calib_done | input | 1 | Memory calibration finished; enables scheduling |
| port_ready | output | 1 | User request port accepts handshakes |
| usr_req | input | NUM_RANKS | Asynchronous per-rank refresh request |
| usr_ack | output | NUM_RANKS | Per-rank acknowledge |
| zq_block | input | 1 | Suppresses periodic ZQ calibration |
| rank_idle | input | NUM_RANKS | Arbiter has no access queued or in flight for the rank |
| rank_block | output | NUM_RANKS | Arbiter must not start new accesses to the rank |
| cmd_valid | output | 1 | Maintenance command offered |
| cmd_op | output | 2 | Command code (see R2) |
| cmd_rank | output | $clog2(NUM_RANKS) | Target rank |
| cmd_ready | input | 1 | Command bus accepts the offered command |

## Verification
If a pending counter drifts or saturates wrongly, the number of refreshes per rank at the command port differs. In internal mode this shows within one refresh interval. In user mode it shows a few sequence lengths after the last handshake. A sequencer that skips the drain or precharge step issues a refresh or ZQ without a preceding accepted precharge-all to the same rank, or while the rank is not idle, and this is visible at the very next command. A broken synchronizer or handshake state shows as an acknowledge that is late, drops while the request is still high, or appears while the port is not ready, all within a few cycles of the request edge.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PREA = 2'd1,
        OP_REF  = 2'd2,
        OP_ZQCS = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DRAIN,
        SQ_PREA,
        SQ_TRP,
        SQ_CMD,
        SQ_TWAIT
    } seq_e;

    typedef enum logic {
        HS_IDLE,
        HS_ACK
    } hs_e;

    // saturating up, floored down; simultaneous inc and dec cancel
    function automatic logic [CNT_W-1:0] pend_next(
        input logic [CNT_W-1:0] c,
        input logic inc,
        input logic dec
    );
        logic [CNT_W-1:0] r;
        r = c;
        if (inc && !dec && c != CNT_MAX)
            r = CNT_W'(c + 1'b1);
        else if (dec && !inc && c != '0)
            r = CNT_W'(c - 1'b1);
        return r;
    endfunction

endpackage

// File: rtl/rfsh_req_sync.sv
module rfsh_req_sync
    import rfsh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    input  logic enable,
    output logic ack,
    output logic inc
);

    logic meta;
    logic req_s;
    hs_e  st;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta  <= 1'b0;
            req_s <= 1'b0;
        end else begin
            meta  <= req_async;
            req_s <= meta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= HS_IDLE;
        end else begin
            case (st)
                HS_IDLE: if (req_s && enable) st <= HS_ACK;
                HS_ACK:  if (!req_s)          st <= HS_IDLE;
                default: st <= HS_IDLE;
            endcase
        end
    end

    assign ack = (st == HS_ACK);
    assign inc = (st == HS_IDLE) && req_s && enable;

    assert_ack_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(req_s));
    assert_ack_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !$past(req_s));
    assert_ack_gated_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(enable));

endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr
    import rfsh_pkg::*;
#(
    parameter int POSTPONE_LIMIT = 6
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             nz,
    output logic             urgent
);

    localparam logic [CNT_W-1:0] LIM = CNT_W'(POSTPONE_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= pend_next(cnt, inc, dec);
    end

    assign nz     = (cnt != '0);
    assign urgent = (cnt >= LIM);

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt != '0));
    assert_single_step_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |->
            (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == CNT_W'($past(cnt) - 1'b1)));
    assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && inc && !dec) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/rfsh_interval_tmr.sv
module rfsh_interval_tmr #(
    parameter int PERIOD = 100
)(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == LAST) ? '0 : CW'(cnt + 1'b1);
    end

    assign tick = run && !restart && (cnt == LAST);

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int NUM_RANKS   = 4,
    parameter int RANK_W      = 2,
    parameter int TRP_CYCLES  = 8,
    parameter int TRFC_CYCLES = 200
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_en,
    input  logic [NUM_RANKS-1:0] urgent,
    input  logic [NUM_RANKS-1:0] pend_nz,
    input  logic [NUM_RANKS-1:0] rank_idle,
    input  logic                 zq_due,
    input  logic [RANK_W-1:0]    zq_rank,
    input  logic                 cmd_ready,
    output logic                 cmd_valid,
    output op_e                  cmd_op,
    output logic [RANK_W-1:0]    cmd_rank,
    output logic [NUM_RANKS-1:0] rank_block,
    output logic                 ref_acc,
    output logic                 zq_taken
);

    localparam int WAIT_MAX = (TRP_CYCLES > TRFC_CYCLES) ? TRP_CYCLES : TRFC_CYCLES;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

    typedef struct packed {
        logic [RANK_W-1:0] rank;
        logic              zq;
    } job_t;

    seq_e                 st;
    job_t                 job;
    job_t                 pick;
    logic                 go;
    logic                 prea_seen;
    logic [WAIT_W-1:0]    wcnt;
    logic                 urg_hit, opp_hit;
    logic [RANK_W-1:0]    urg_idx, opp_idx;
    logic [NUM_RANKS-1:0] opp;

    // selection: urgent first, then due ZQ on an idle rank, then idle pending
    always_comb begin
        opp     = pend_nz & rank_idle;
        urg_hit = 1'b0;
        urg_idx = '0;
        opp_hit = 1'b0;
        opp_idx = '0;
        for (int i = NUM_RANKS - 1; i >= 0; i--) begin
            if (urgent[i]) begin
                urg_hit = 1'b1;
                urg_idx = RANK_W'(i);
            end
            if (opp[i]) begin
                opp_hit = 1'b1;
                opp_idx = RANK_W'(i);
            end
        end
        go   = 1'b0;
        pick = '0;
        if (run_en) begin
            if (urg_hit) begin
                go        = 1'b1;
                pick.rank = urg_idx;
            end else if (zq_due && rank_idle[zq_rank]) begin
                go        = 1'b1;
                pick.rank = zq_rank;
                pick.zq   = 1'b1;
            end else if (opp_hit) begin
                go        = 1'b1;
                pick.rank = opp_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            job       <= '0;
            wcnt      <= '0;
            prea_seen <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    prea_seen <= 1'b0;
                    if (go) begin
                        job <= pick;
                        st  <= SQ_DRAIN;
                    end
                end
                SQ_DRAIN: if (rank_idle[job.rank]) st <= SQ_PREA;
                SQ_PREA: if (cmd_ready) begin
                    prea_seen <= 1'b1;
                    wcnt      <= '0;
                    st        <= SQ_TRP;
                end
                SQ_TRP: begin
                    if (wcnt == WAIT_W'(TRP_CYCLES - 1)) st <= SQ_CMD;
                    else wcnt <= WAIT_W'(wcnt + 1'b1);
                end
                SQ_CMD: if (cmd_ready) begin
                    wcnt <= '0;
                    st   <= SQ_TWAIT;
                end
                SQ_TWAIT: begin
                    if (wcnt == WAIT_W'(TRFC_CYCLES - 1)) st <= SQ_IDLE;
                    else wcnt <= WAIT_W'(wcnt + 1'b1);
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_valid  = (st == SQ_PREA) || (st == SQ_CMD);
        cmd_op     = OP_NONE;
        if (st == SQ_PREA)     cmd_op = OP_PREA;
        else if (st == SQ_CMD) cmd_op = job.zq ? OP_ZQCS : OP_REF;
        cmd_rank   = job.rank;
        rank_block = '0;
        if (st != SQ_IDLE) rank_block[job.rank] = 1'b1;
    end

    assign ref_acc  = (st == SQ_CMD) && cmd_ready && !job.zq;
    assign zq_taken = (st == SQ_CMD) && cmd_ready &&  job.zq;

    assert_ref_after_prea_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op != OP_PREA) |-> prea_seen);
    assert_idle_before_prea_R1: assert property (@(posedge clk) disable iff (rst)
        ($rose(cmd_valid) && cmd_op == OP_PREA) |-> $past(rank_idle[cmd_rank]));
    assert_hold_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_rank)));

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int NUM_RANKS      = 4,
    parameter int USER_MODE      = 0,
    parameter int REFI_CYCLES    = 7800,
    parameter int POSTPONE_LIMIT = 6,
    parameter int TRP_CYCLES     = 8,
    parameter int TRFC_CYCLES    = 200,
    parameter int ZQ_CYCLES      = 100000,
    localparam int RANK_W        = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 calib_done,
    output logic                 port_ready,
    input  logic [NUM_RANKS-1:0] usr_req,
    output logic [NUM_RANKS-1:0] usr_ack,
    input  logic                 zq_block,
    input  logic [NUM_RANKS-1:0] rank_idle,
    output logic [NUM_RANKS-1:0] rank_block,
    output logic                 cmd_valid,
    output logic [1:0]           cmd_op,
    output logic [RANK_W-1:0]    cmd_rank,
    input  logic                 cmd_ready
);

    logic                 calib_q;
    logic [NUM_RANKS-1:0] inc_v;
    logic [NUM_RANKS-1:0] dec_v;
    logic [NUM_RANKS-1:0] pend_nz;
    logic [NUM_RANKS-1:0] urgent;
    logic                 ref_acc;
    logic                 zq_taken;
    op_e                  seq_op;
    logic                 zq_run;
    logic                 zq_due;
    logic                 zq_arm;
    logic                 zq_tick;
    logic [RANK_W-1:0]    zq_rank;

    always_ff @(posedge clk) begin
        if (rst) calib_q <= 1'b0;
        else     calib_q <= calib_done;
    end

    assign port_ready = (USER_MODE != 0) && calib_q;

    generate
        if (USER_MODE != 0) begin : g_user
            for (genvar r = 0; r < NUM_RANKS; r++) begin : g_hs
                rfsh_req_sync u_hs (
                    .clk       (clk),
                    .rst       (rst),
                    .req_async (usr_req[r]),
                    .enable    (port_ready),
                    .ack       (usr_ack[r]),
                    .inc       (inc_v[r])
                );
            end
        end else begin : g_internal
            logic refi_tick;
            logic unused_req;
            assign unused_req = ^usr_req;
            rfsh_interval_tmr #(.PERIOD(REFI_CYCLES)) u_refi (
                .clk     (clk),
                .rst     (rst),
                .run     (1'b1),
                .restart (1'b0),
                .tick    (refi_tick)
            );
            assign inc_v   = {NUM_RANKS{refi_tick}};
            assign usr_ack = '0;

            always @(posedge clk) begin
                if (!rst) assert_ack_quiet_R7: assert (usr_ack == '0);
            end
        end
    endgenerate

    generate
        for (genvar r = 0; r < NUM_RANKS; r++) begin : g_pend
            logic [CNT_W-1:0] cnt;
            assign dec_v[r] = ref_acc && (cmd_rank == RANK_W'(r));
            rfsh_pend_ctr #(.POSTPONE_LIMIT(POSTPONE_LIMIT)) u_ctr (
                .clk    (clk),
                .rst    (rst),
                .inc    (inc_v[r]),
                .dec    (dec_v[r]),
                .cnt    (cnt),
                .nz     (pend_nz[r]),
                .urgent (urgent[r])
            );
        end
    endgenerate

    // ZQ timer: armed by a refresh only when no ZQ is running or waiting
    assign zq_arm = ref_acc && !zq_run && !zq_due;

    rfsh_interval_tmr #(.PERIOD(ZQ_CYCLES)) u_zq (
        .clk     (clk),
        .rst     (rst),
        .run     (zq_run),
        .restart (zq_arm),
        .tick    (zq_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            zq_run  <= 1'b0;
            zq_due  <= 1'b0;
            zq_rank <= '0;
        end else begin
            if (zq_arm) begin
                zq_run  <= 1'b1;
                zq_rank <= cmd_rank;
            end else if (zq_tick) begin
                zq_run  <= 1'b0;
            end
            if (zq_tick && !zq_block)   zq_due <= 1'b1;
            else if (zq_taken || zq_block) zq_due <= 1'b0;
        end
    end

    rfsh_seq #(
        .NUM_RANKS   (NUM_RANKS),
        .RANK_W      (RANK_W),
        .TRP_CYCLES  (TRP_CYCLES),
        .TRFC_CYCLES (TRFC_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .run_en     (calib_q),
        .urgent     (urgent),
        .pend_nz    (pend_nz),
        .rank_idle  (rank_idle),
        .zq_due     (zq_due),
        .zq_rank    (zq_rank),
        .cmd_ready  (cmd_ready),
        .cmd_valid  (cmd_valid),
        .cmd_op     (seq_op),
        .cmd_rank   (cmd_rank),
        .rank_block (rank_block),
        .ref_acc    (ref_acc),
        .zq_taken   (zq_taken)
    );

    assign cmd_op = seq_op;

    assert_block_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rank_block));
    assert_zq_not_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        zq_block |=> !zq_due);

endmodule

// File: tb/rfsh_sched_test.sv
module rfsh_sched_test;

    localparam int NR = 4, REFI = 100, TRP = 3, TRFC = 6, ZQC = 60, LIM = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int cyc = 0, checks = 0, fails = 0;
    bit done = 1'b0;

    // internal-mode instance signals
    logic          calib_i = 1'b0, zqb_i = 1'b1, ready_i = 1'b1;
    logic [NR-1:0] req_i = '0, traffic_i = '0, idle_i, block_i, ack_i;
    logic          pr_i, valid_i;
    logic [1:0]    op_i, rank_i;
    // user-mode instance signals
    logic          calib_u = 1'b0, zqb_u = 1'b0, ready_u = 1'b1;
    logic [NR-1:0] req_u = '0, traffic_u = '0, idle_u, block_u, ack_u;
    logic          pr_u, valid_u;
    logic [1:0]    op_u, rank_u;

    rfsh_sched #(.NUM_RANKS(NR), .USER_MODE(0), .REFI_CYCLES(REFI), .POSTPONE_LIMIT(LIM),
                 .TRP_CYCLES(TRP), .TRFC_CYCLES(TRFC), .ZQ_CYCLES(ZQC)) uut (
        .clk(clk), .rst(rst), .calib_done(calib_i), .port_ready(pr_i), .usr_req(req_i),
        .usr_ack(ack_i), .zq_block(zqb_i), .rank_idle(idle_i), .rank_block(block_i),
        .cmd_valid(valid_i), .cmd_op(op_i), .cmd_rank(rank_i), .cmd_ready(ready_i));

    rfsh_sched #(.NUM_RANKS(NR), .USER_MODE(1), .REFI_CYCLES(REFI), .POSTPONE_LIMIT(LIM),
                 .TRP_CYCLES(TRP), .TRFC_CYCLES(TRFC), .ZQ_CYCLES(ZQC)) uut_u (
        .clk(clk), .rst(rst), .calib_done(calib_u), .port_ready(pr_u), .usr_req(req_u),
        .usr_ack(ack_u), .zq_block(zqb_u), .rank_idle(idle_u), .rank_block(block_u),
        .cmd_valid(valid_u), .cmd_op(op_u), .cmd_rank(rank_u), .cmd_ready(ready_u));

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    // arbiter model: a busy rank drains three cycles after it is blocked
    int dc_i [NR];
    int dc_u [NR];
    always @(posedge clk) begin
        for (int r = 0; r < NR; r++) begin
            dc_i[r] <= block_i[r] ? ((dc_i[r] < 3) ? dc_i[r] + 1 : 3) : 0;
            dc_u[r] <= block_u[r] ? ((dc_u[r] < 3) ? dc_u[r] + 1 : 3) : 0;
        end
    end
    always_comb begin
        for (int r = 0; r < NR; r++) begin
            idle_i[r] = !traffic_i[r] || (dc_i[r] >= 3);
            idle_u[r] = !traffic_u[r] || (dc_u[r] >= 3);
        end
    end

    // command monitors
    int  refs_i [NR], refs_u [NR], zqs_u [NR], zqs_i [NR];
    bit  pre_i [NR], pre_u [NR];
    int  ord_err = 0, blk_err = 0, stab_err = 0, ackq_err = 0, last_ref_u = 0;
    bit  hold_i = 0, hold_u = 0;
    logic [1:0] hop_i, hrk_i, hop_u, hrk_u;
    initial for (int r = 0; r < NR; r++) begin
        refs_i[r] = 0; refs_u[r] = 0; zqs_u[r] = 0; zqs_i[r] = 0; pre_i[r] = 0; pre_u[r] = 0;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (ack_i != '0 || pr_i) ackq_err++;
            if (hold_i && !(valid_i && op_i == hop_i && rank_i == hrk_i)) stab_err++;
            if (hold_u && !(valid_u && op_u == hop_u && rank_u == hrk_u)) stab_err++;
            hold_i = valid_i && !ready_i; hop_i = op_i; hrk_i = rank_i;
            hold_u = valid_u && !ready_u; hop_u = op_u; hrk_u = rank_u;
            if (valid_i && !block_i[rank_i]) blk_err++;
            if (valid_u && !block_u[rank_u]) blk_err++;
            if (valid_i && ready_i) begin
                if (op_i == 2'd1) begin
                    if (!idle_i[rank_i]) blk_err++;
                    pre_i[rank_i] = 1;
                end else begin
                    if (!pre_i[rank_i]) ord_err++;
                    pre_i[rank_i] = 0;
                    if (op_i == 2'd2) refs_i[rank_i]++; else zqs_i[rank_i]++;
                end
            end
            if (valid_u && ready_u) begin
                if (op_u == 2'd1) begin
                    if (!idle_u[rank_u]) blk_err++;
                    pre_u[rank_u] = 1;
                end else begin
                    if (!pre_u[rank_u]) ord_err++;
                    pre_u[rank_u] = 0;
                    if (op_u == 2'd2) begin refs_u[rank_u]++; last_ref_u = cyc; end
                    else zqs_u[rank_u]++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) step;
    endtask

    function automatic int zq_total();
        int s = 0;
        for (int r = 0; r < NR; r++) s += zqs_u[r];
        return s;
    endfunction

    // one full four-phase handshake on user rank r (R6 timing checked inline)
    task automatic hs(input int r);
        int lat = 0;
        bit ok = 1;
        req_u[r] = 1'b1;
        while (!ack_u[r] && lat < 40) begin step; lat++; end
        chk(ack_u[r] && lat <= 16, "R6 ack latency", lat, 16);
        repeat (20) begin step; if (!ack_u[r]) ok = 0; end
        chk(ok, "R6 ack held while request high", ok, 1);
        req_u[r] = 1'b0;
        step;
        chk(ack_u[r] == 1'b1, "R6 ack waits for synced low", ack_u[r], 1);
        lat = 0;
        while (ack_u[r] && lat < 40) begin step; lat++; end
        chk(!ack_u[r], "R6 ack release", ack_u[r], 0);
    endtask

    always @(posedge clk) begin
        if (cyc >= 20000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int b, z0;
        repeat (4) step;
        chk(!valid_i && !valid_u && block_i == '0 && block_u == '0, "R2 reset idle", valid_u, 0);
        chk(ack_u == '0 && !pr_u, "R7 reset ack and ready low", ack_u, 0);
        rst = 1'b0;
        calib_i = 1'b1;
        req_u[0] = 1'b1;  // held while user port is not ready: must be ignored

        wait_cyc(590);
        for (int r = 0; r < NR; r++)
            chk(refs_i[r] == 5, "R3 refreshes after five intervals", refs_i[r], 5);
        chk(ack_u == '0, "R7 request ignored before ready", ack_u, 0);
        chk(refs_u[0] == 0, "R7 no refresh before ready", refs_u[0], 0);
        traffic_i[2] = 1'b1;

        wait_cyc(1090);
        chk(refs_i[2] == 5, "R4 busy rank postponed", refs_i[2], 5);
        chk(block_i[2] == 1'b0, "R4 busy rank not yet forced", block_i[2], 0);
        for (int r = 0; r < NR; r++)
            if (r != 2) chk(refs_i[r] == 10, "R3 idle ranks keep pace", refs_i[r], 10);

        wait_cyc(1190);
        chk(refs_i[2] == 6, "R4 forced at limit", refs_i[2], 6);
        for (int r = 0; r < NR; r++)
            if (r != 2) chk(refs_i[r] == 11, "R3 idle ranks after eleven", refs_i[r], 11);
        traffic_i[2] = 1'b0;

        req_u[0] = 1'b0;
        repeat (10) step;
        calib_u = 1'b1;
        repeat (3) step;
        chk(pr_u == 1'b1, "R7 ready follows calibration", pr_u, 1);
        chk(ack_u == '0, "R7 stale request not acknowledged", ack_u, 0);

        for (int r = 0; r < NR; r++)
            for (int n = 0; n <= r; n++) begin
                hs(r);
                repeat (30) step;
            end
        repeat (40) step;
        for (int r = 0; r < NR; r++)
            chk(refs_u[r] == r + 1, "R5 one refresh per handshake", refs_u[r], r + 1);

        traffic_u[0] = 1'b1;
        hs(0);
        repeat (100) step;
        chk(refs_u[0] == 1, "R4 pending waits for idle rank", refs_u[0], 1);
        chk(block_u == '0, "R4 no block below limit", block_u, 0);
        traffic_u[0] = 1'b0;
        repeat (40) step;
        chk(refs_u[0] == 2, "R4 served once idle", refs_u[0], 2);

        repeat (200) step;
        z0 = zq_total();
        b  = zqs_u[1];
        hs(1);
        wait_cyc(last_ref_u + ZQC - 8);
        chk(zq_total() == z0, "R9 no ZQ before interval", zq_total(), z0);
        wait_cyc(last_ref_u + ZQC + 32);
        chk(zq_total() == z0 + 1 && zqs_u[1] == b + 1, "R9 ZQ after interval", zqs_u[1], b + 1);

        repeat (200) step;
        zqb_u = 1'b1;
        z0 = zq_total();
        b  = refs_u[2];
        hs(2);
        repeat (150) step;
        chk(refs_u[2] == b + 1, "R5 refresh with ZQ blocked", refs_u[2], b + 1);
        chk(zq_total() == z0, "R9 ZQ suppressed", zq_total(), z0);

        ready_u = 1'b0;
        b = refs_u[3];
        repeat (9) hs(3);
        ready_u = 1'b1;
        repeat (300) step;
        chk(refs_u[3] == b + 7, "R8 counter saturates at seven", refs_u[3], b + 7);

        chk(ord_err == 0, "R1 precharge-all precedes refresh/ZQ", ord_err, 0);
        chk(blk_err == 0, "R1 rank blocked and idle for commands", blk_err, 0);
        chk(stab_err == 0, "R2 command held until ready", stab_err, 0);
        chk(ackq_err == 0, "R7 internal mode ack and ready quiet", ackq_err, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule